// File: doc/BRIEF.md
# Tuner Power State Controller

This block is the device-side controller that decides which power mode a broadcast tuner is in. An external active-low reset pin holds the device fully inactive with every register at its default value. When the pin is released, the controller samples a strap input to fix the serial bus mode. It then enters a low-power standby state in which the bus is usable and register contents are kept. From there, host writes of two control bits, an enable bit and a disable bit, move the device between modes.

Writing enable=1 and disable=0 brings the device into normal operation. Writing enable=1 and disable=1 starts an internal shutdown sequence. The sequence lasts a fixed number of clock cycles, and at its end the controller clears the enable bit by itself and returns to standby. Writing enable=0 directly is an undesirable path: it lands in a separate partial-powerdown state, which the controller reports on its own code. The control-bit read-back values follow the current state, so the host can see where the device stands.

Top module: `tuner_power_ctrl`

## Requirements
- R1: While `rst_pin_n` is low, `pwr_state` is 0 (reset), `bus_active` is 0, `bus_mode` is 0, and both read-back bits are 0. Writes have no effect.
- R2: After `rst_pin_n` rises, the synchronised reset clears on the `SYNC_STAGES`-th rising clock edge. On the next edge, `pwr_state` becomes 1 (standby) and `bus_active` becomes 1. On that same edge, `bus_mode` takes the value of `strap_sen` (1 selects 2-wire, 0 selects 3-wire).
- R3: `bus_mode` keeps its latched value through all state changes until reset is asserted again, whatever `strap_sen` does.
- R4: In standby (`pwr_state`=1), `rd_enable` and `rd_disable` are both 0. A write of enable=1 and disable=1 in standby changes nothing.
- R5: A write of enable=1 and disable=0, accepted in standby, normal or partial-powerdown, sets `pwr_state` to 2 (normal) on the next edge, with `rd_enable`=1 and `rd_disable`=0.
- R6: A write of enable=1 and disable=1, accepted in normal or partial-powerdown, starts the shutdown sequence. On the next edge both read-back bits are 1 and `pwr_state` does not change. On the `PD_CYCLES`-th edge after the accepting edge, `pwr_state` becomes 1 and both read-back bits become 0.
- R7: Every write presented while the shutdown sequence runs is ignored, including on the edge where the sequence completes.
- R8: A write with enable=0, accepted in any state except reset, sets `pwr_state` to 3 (partial powerdown) on the next edge. `rd_enable` then reads 0 and `rd_disable` reads the written disable value.
- R9: Asserting `rst_pin_n` low at any time, including during the shutdown sequence, returns every output to its R1 values at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous assertion |
| strap_sen | input | 1 | Bus-mode strap, sampled once as reset is released |
| wr_en | input | 1 | Strobe for a write of the control bits |
| wr_enable | input | 1 | Enable bit value of the write |
| wr_disable | input | 1 | Disable bit value of the write |
| pwr_state | output | 2 | 0 reset, 1 standby, 2 normal, 3 partial powerdown |
| bus_mode | output | 1 | Latched bus mode, 1 = 2-wire, 0 = 3-wire |
| rd_enable | output | 1 | Read-back value of the enable bit |
| rd_disable | output | 1 | Read-back value of the disable bit |
| bus_active | output | 1 | High when the register bus is accessible |

## Verification
The hardest situation to reach is a write that collides with the last cycle of the shutdown sequence, or a reset that lands in the middle of it. Either one needs a write placed an exact number of edges after the write that started the sequence. The bench holds the write strobe high for the whole sequence so that every cycle, including the completing one, sees a competing write. It also drops the reset pin partway through a later sequence, with the strap flipped, to check that the bus mode is captured again. A long run of random writes, with the bench model tracking the sequence countdown, then covers collisions at arbitrary offsets from every state.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

  typedef enum logic [1:0] {
    PS_RESET   = 2'd0,
    PS_STANDBY = 2'd1,
    PS_ACTIVE  = 2'd2,
    PS_PARTIAL = 2'd3
  } pwr_state_e;

  typedef struct packed {
    logic en;
    logic dis;
  } ctl_bits_t;

  localparam ctl_bits_t CTL_OFF = '{en: 1'b0, dis: 1'b0};

endpackage

// File: rtl/tpc_reset_sync.sv
module tpc_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_pin_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_pin_n) begin
        if (!rst_pin_n) chain_q <= '0;
        else            chain_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_pin_n) begin
        if (!rst_pin_n) chain_q <= '0;
        else            chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/tpc_pd_timer.sv
module tpc_pd_timer #(
  parameter int PD_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);

  localparam int CW = (PD_CYCLES > 1) ? $clog2(PD_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(PD_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          upd;

  assign done = busy_q && (cnt_q == '0);
  assign busy = busy_q;
  assign upd  = start || busy_q;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start) begin
      cnt_d  = LOAD;
      busy_d = 1'b1;
    end else if (done) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (upd) begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

endmodule

// File: rtl/tpc_mode_fsm.sv
module tpc_mode_fsm
  import tpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap,
  input  logic       wr_en,
  input  ctl_bits_t  wr_bits,
  input  logic       seq_busy,
  input  logic       seq_done,
  output logic       seq_start,
  output pwr_state_e state,
  output logic       bus_mode,
  output ctl_bits_t  rd_bits
);

  pwr_state_e state_q, state_d;
  ctl_bits_t  rd_q, rd_d;
  logic       mode_q;
  logic       upd, take_wr, capture;

  assign capture = (state_q == PS_RESET);
  assign take_wr = wr_en && !seq_busy && !capture;
  assign upd     = capture || seq_done || take_wr;

  always_comb begin
    state_d   = state_q;
    rd_d      = rd_q;
    seq_start = 1'b0;
    if (capture) begin
      state_d = PS_STANDBY;
      rd_d    = CTL_OFF;
    end else if (seq_done) begin
      state_d = PS_STANDBY;
      rd_d    = CTL_OFF;
    end else if (take_wr) begin
      if (!wr_bits.en) begin
        state_d = PS_PARTIAL;
        rd_d    = '{en: 1'b0, dis: wr_bits.dis};
      end else if (!wr_bits.dis) begin
        state_d = PS_ACTIVE;
        rd_d    = '{en: 1'b1, dis: 1'b0};
      end else if (state_q != PS_STANDBY) begin
        seq_start = 1'b1;
        rd_d      = '{en: 1'b1, dis: 1'b1};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_RESET;
      rd_q    <= CTL_OFF;
    end else if (upd) begin
      state_q <= state_d;
      rd_q    <= rd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= 1'b0;
    else if (capture) mode_q <= strap;
  end

  assign state    = state_q;
  assign bus_mode = mode_q;
  assign rd_bits  = rd_q;

endmodule

// File: rtl/tuner_power_ctrl.sv
module tuner_power_ctrl
  import tpc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PD_CYCLES   = 16
) (
  input  logic       clk,
  input  logic       rst_pin_n,
  input  logic       strap_sen,
  input  logic       wr_en,
  input  logic       wr_enable,
  input  logic       wr_disable,
  output logic [1:0] pwr_state,
  output logic       bus_mode,
  output logic       rd_enable,
  output logic       rd_disable,
  output logic       bus_active
);

  logic       rst_n_sync;
  logic       seq_start, seq_busy, seq_done;
  pwr_state_e state;
  ctl_bits_t  rd_bits;
  ctl_bits_t  wr_bits;

  assign wr_bits = '{en: wr_enable, dis: wr_disable};

  tpc_reset_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_pin_n  (rst_pin_n),
    .rst_n_sync (rst_n_sync)
  );

  tpc_pd_timer #(.PD_CYCLES(PD_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .start (seq_start),
    .busy  (seq_busy),
    .done  (seq_done)
  );

  tpc_mode_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .strap     (strap_sen),
    .wr_en     (wr_en),
    .wr_bits   (wr_bits),
    .seq_busy  (seq_busy),
    .seq_done  (seq_done),
    .seq_start (seq_start),
    .state     (state),
    .bus_mode  (bus_mode),
    .rd_bits   (rd_bits)
  );

  assign pwr_state  = state;
  assign rd_enable  = rd_bits.en;
  assign rd_disable = rd_bits.dis;
  assign bus_active = (state != PS_RESET);

endmodule

// File: rtl/tpc_checker.sv
module tpc_checker (
  input logic       clk,
  input logic       rst_pin_n,
  input logic       wr_en,
  input logic       wr_enable,
  input logic       wr_disable,
  input logic [1:0] pwr_state,
  input logic       bus_mode,
  input logic       rd_enable,
  input logic       rd_disable,
  input logic       bus_active
);

  // R3: bus mode frozen once out of reset
  p_mode_frozen_r3: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (pwr_state != 2'd0 && $past(pwr_state) != 2'd0) |-> $stable(bus_mode));

  // R4: standby reads both bits as zero
  p_standby_reads_r4: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (pwr_state == 2'd1) |-> (!rd_enable && !rd_disable));

  // R1: the reset state reads zeros and the bus is idle
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (pwr_state == 2'd0) |-> (!rd_enable && !rd_disable && !bus_active && !bus_mode));

  // R5: wake-up write from standby reaches normal operation
  p_wake_r5: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (pwr_state == 2'd1 && wr_en && wr_enable && !wr_disable) |=> (pwr_state == 2'd2));

  // R6: normal to standby only at the end of a shutdown sequence
  p_seq_end_r6: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (pwr_state == 2'd1 && $past(pwr_state) == 2'd2) |-> $past(rd_enable && rd_disable));

  // R8: partial powerdown never reads enable without disable
  p_partial_reads_r8: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (pwr_state == 2'd3 && !rd_disable) |-> !rd_enable);

endmodule

bind tuner_power_ctrl tpc_checker u_chk (
  .clk        (clk),
  .rst_pin_n  (rst_pin_n),
  .wr_en      (wr_en),
  .wr_enable  (wr_enable),
  .wr_disable (wr_disable),
  .pwr_state  (pwr_state),
  .bus_mode   (bus_mode),
  .rd_enable  (rd_enable),
  .rd_disable (rd_disable),
  .bus_active (bus_active)
);

// File: tb/tuner_power_ctrl_test.sv
`timescale 1ns/1ps
module tuner_power_ctrl_test;

  localparam int SYNC = 2;
  localparam int PDC  = 16;

  logic       clk = 1'b0;
  logic       rst_pin_n = 1'b0;
  logic       strap_sen = 1'b1;
  logic       wr_en = 1'b0;
  logic       wr_enable = 1'b0;
  logic       wr_disable = 1'b0;
  logic [1:0] pwr_state;
  logic       bus_mode, rd_enable, rd_disable, bus_active;

  int    vecs = 0;
  int    fails = 0;
  bit    running = 0;
  bit    finished = 0;
  string req = "R1";

  // reference model state
  int m_sync, m_state, m_mode, m_ren, m_rdis, m_left;

  always #2 clk = ~clk;

  tuner_power_ctrl #(.SYNC_STAGES(SYNC), .PD_CYCLES(PDC)) uut (
    .clk(clk), .rst_pin_n(rst_pin_n), .strap_sen(strap_sen),
    .wr_en(wr_en), .wr_enable(wr_enable), .wr_disable(wr_disable),
    .pwr_state(pwr_state), .bus_mode(bus_mode), .rd_enable(rd_enable),
    .rd_disable(rd_disable), .bus_active(bus_active)
  );

  always @(posedge clk or negedge rst_pin_n) begin
    if (!rst_pin_n) begin
      m_sync = 0; m_state = 0; m_mode = 0; m_ren = 0; m_rdis = 0; m_left = 0;
    end else if (m_sync < SYNC) begin
      m_sync = m_sync + 1;
    end else if (m_state == 0) begin
      m_state = 1; m_mode = strap_sen;
    end else if (m_left > 0) begin
      m_left = m_left - 1;
      if (m_left == 0) begin m_state = 1; m_ren = 0; m_rdis = 0; end
    end else if (wr_en) begin
      if (!wr_enable) begin
        m_state = 3; m_ren = 0; m_rdis = wr_disable;
      end else if (!wr_disable) begin
        m_state = 2; m_ren = 1; m_rdis = 0;
      end else if (m_state != 1) begin
        m_left = PDC; m_ren = 1; m_rdis = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (running) begin
      vecs++;
      if (pwr_state !== 2'(m_state) || bus_mode !== 1'(m_mode) ||
          rd_enable !== 1'(m_ren) || rd_disable !== 1'(m_rdis) ||
          bus_active !== (m_state != 0)) begin
        fails++;
        $display("FAIL %s t=%0t got st=%0d mode=%0b en=%0b dis=%0b act=%0b exp st=%0d mode=%0d en=%0d dis=%0d act=%0b",
                 req, $time, pwr_state, bus_mode, rd_enable, rd_disable, bus_active,
                 m_state, m_mode, m_ren, m_rdis, (m_state != 0));
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic write(input logic e, input logic d);
    wr_en = 1'b1; wr_enable = e; wr_disable = d;
    step(1);
    wr_en = 1'b0;
  endtask

  initial begin
    #800000;
    if (!finished) begin
      fails++;
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    step(1);
    running = 1;
    // R1: writes while in reset do nothing
    req = "R1";
    write(1'b1, 1'b0);
    write(1'b0, 1'b1);
    step(2);
    // R2: release with strap high (2-wire)
    req = "R2";
    rst_pin_n = 1'b1;
    step(SYNC + 2);
    // R4: shutdown write in standby is ignored
    req = "R4";
    write(1'b1, 1'b1);
    step(2);
    // R5: standby to normal
    req = "R5";
    write(1'b1, 1'b0);
    step(1);
    // R8: direct clear of enable
    req = "R8";
    write(1'b0, 1'b1);
    step(1);
    write(1'b0, 1'b0);
    step(1);
    // R5: partial back to normal
    req = "R5";
    write(1'b1, 1'b0);
    // R6: shutdown sequence from normal
    req = "R6";
    write(1'b1, 1'b1);
    // R7: writes held across the whole sequence, completion edge included
    req = "R7";
    wr_en = 1'b1; wr_enable = 1'b0; wr_disable = 1'b1;
    step(PDC - 1);
    wr_enable = 1'b1; wr_disable = 1'b0;
    step(1);
    wr_en = 1'b0;
    step(2);
    // R8: partial from standby, then R6 sequence from partial
    req = "R8";
    write(1'b0, 1'b0);
    req = "R6";
    write(1'b1, 1'b1);
    step(PDC + 2);
    // R3: strap changes while running have no effect
    req = "R3";
    strap_sen = 1'b0;
    write(1'b1, 1'b0);
    step(3);
    strap_sen = 1'b1;
    step(2);
    // R9: reset during a sequence, new strap value low (3-wire)
    req = "R9";
    write(1'b1, 1'b1);
    step(5);
    strap_sen = 1'b0;
    rst_pin_n = 1'b0;
    step(3);
    req = "R2";
    rst_pin_n = 1'b1;
    step(SYNC + 3);
    strap_sen = 1'b1;
    // mixed random traffic, covers R5 R6 R7 R8
    req = "R7";
    for (int i = 0; i < 600; i++) begin
      wr_en      = ($urandom_range(0, 3) == 0);
      wr_enable  = 1'($urandom_range(0, 1));
      wr_disable = 1'($urandom_range(0, 1));
      step(1);
    end
    wr_en = 1'b0;
    step(PDC + 2);
    running = 0;
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule